// File: doc/BRIEF.md
# Serial-Loaded Digital Potentiometer Controller

This block is the digital side of a 128-position digital potentiometer. A host loads a seven-bit wiper code through a three-wire serial port: a chip select, a serial clock and a data line. While chip select is low, each rising serial-clock edge shifts one bit into a seven-bit shift register, most significant bit first. When chip select rises, the shift register is copied into the wiper latch. The serial pins are sampled in a faster system-clock domain. A parameterised synchronizer chain and an edge detector turn the pin activity into single-cycle shift and load events.

The latch code is decoded into a one-hot tap select. Two flags report the state of the switch to terminal A and whether the wiper is shorted to terminal B. An active-low midscale reset forces the latch to the centre code and clears the shift register. An active-low shutdown opens the terminal-A switch and parks the wiper on terminal B, while the latch keeps its value and can still be reprogrammed. A daisy-chain output presents the bit that entered the shift register seven shifts earlier. This output is modelled as an open-drain pull-low enable, so several devices can be chained on one select and clock.

Top module: `dpot_ctrl`

## Requirements
- R1: While the synchronised chip select is low, each rising edge of the serial clock shifts the data bit into bit 0 of the shift register, and earlier bits move one place toward bit 6. A word therefore arrives most significant bit first.
- R2: A rising edge of chip select copies the seven-bit shift register into the wiper latch, which is visible on `wiper_code`.
- R3: When more than seven bits are clocked within one frame, the latch receives only the last seven bits and the earlier ones are lost.
- R4: `sdo_pull_low` is high only while chip select is low, shutdown is inactive and shift-register bit 6 (the bit entered seven shifts earlier) is 0; otherwise the output is released. A second device whose data input sees the pulled-up line therefore latches the first seven bits of a fourteen-bit frame, and the first device latches the last seven.
- R5: While chip select is high, serial-clock edges change neither the shift register nor the latch.
- R6: While `mid_rst_n` is low, the latch reads 0x40 and the shift register is cleared to 0x00. A chip-select rise during reset loads nothing, and the latch still reads 0x40 after reset is released.
- R7: While `shdn_n` is low, `sw_a_closed` is 0, `wiper_to_b` is 1, `sdo_pull_low` is 0, `tap_sel` has only bit 0 set, and the latch keeps its value. When shutdown is released, the tap select for the held code returns.
- R8: A frame loaded while shutdown is low updates `wiper_code` immediately. The new code drives `tap_sel` once shutdown is released.
- R9: Outside shutdown, `tap_sel` has exactly the bit with index equal to the latch code D (0 to 127) set, with bit 0 at the terminal-B end, and `sw_a_closed` is 1 while `wiper_to_b` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| mid_rst_n | input | 1 | Active-low asynchronous midscale reset |
| shdn_n | input | 1 | Active-low shutdown |
| cs_n | input | 1 | Active-low chip select of the serial port |
| sclk | input | 1 | Serial clock; a rising edge shifts data in |
| sdi | input | 1 | Serial data input |
| sdo_pull_low | output | 1 | Daisy-chain output; 1 pulls the line low, 0 releases it |
| wiper_code | output | 7 | Current contents of the wiper latch |
| tap_sel | output | 128 | One-hot tap select; bit 0 is the terminal-B end |
| sw_a_closed | output | 1 | The switch to terminal A is closed |
| wiper_to_b | output | 1 | The wiper is shorted to terminal B |

## Verification
The bench builds two instances with the default seven-bit code and a two-stage synchronizer. The second instance takes its data from the first one's released-or-pulled-low output, so fourteen-bit frames exercise the seven-shift delay end to end. Random frame lengths of seven to ten bits cover the case where leading bits are discarded. Random shutdown around frames covers reprogramming while the wiper is parked. Directed cases add clock activity with chip select high, a load with no clock edges after reset, and a chip-select rise during reset.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned CODE_W_DEF = 7;

  function automatic int unsigned tap_count(input int unsigned code_w);
    return 32'd1 << code_w;
  endfunction

  function automatic int unsigned midscale(input int unsigned code_w);
    return 32'd1 << (code_w - 1);
  endfunction
endpackage

// File: rtl/dpot_sampler.sv
module dpot_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_sync_n,
  output logic sdi_s,
  output logic shift_evt,
  output logic load_evt
);
  logic [SYNC_STAGES-1:0] cs_chain, sclk_chain, sdi_chain;
  logic cs_prev, sclk_prev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cs_chain[g]   <= 1'b1;
            sclk_chain[g] <= 1'b0;
            sdi_chain[g]  <= 1'b0;
          end else begin
            cs_chain[g]   <= cs_n;
            sclk_chain[g] <= sclk;
            sdi_chain[g]  <= sdi;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cs_chain[g]   <= 1'b1;
            sclk_chain[g] <= 1'b0;
            sdi_chain[g]  <= 1'b0;
          end else begin
            cs_chain[g]   <= cs_chain[g-1];
            sclk_chain[g] <= sclk_chain[g-1];
            sdi_chain[g]  <= sdi_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_chain[SYNC_STAGES-1];
      sclk_prev <= sclk_chain[SYNC_STAGES-1];
    end
  end

  assign cs_sync_n = cs_chain[SYNC_STAGES-1];
  assign sdi_s     = sdi_chain[SYNC_STAGES-1];
  assign shift_evt = sclk_chain[SYNC_STAGES-1] & ~sclk_prev & ~cs_sync_n;
  assign load_evt  = cs_sync_n & ~cs_prev;
endmodule

// File: rtl/dpot_shifter.sv
module dpot_shifter #(
  parameter int unsigned CODE_W = dpot_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_evt,
  input  logic              load_evt,
  input  logic              sdi_s,
  output logic [CODE_W-1:0] sr_q,
  output logic [CODE_W-1:0] latch_q
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(dpot_pkg::midscale(CODE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (shift_evt) begin
      sr_q <= {sr_q[CODE_W-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= MID;
    end else if (load_evt) begin
      latch_q <= sr_q;
    end
  end
endmodule

// File: rtl/dpot_decoder.sv
module dpot_decoder #(
  parameter int unsigned CODE_W = dpot_pkg::CODE_W_DEF,
  localparam int unsigned TAPS = dpot_pkg::tap_count(CODE_W)
) (
  input  logic [CODE_W-1:0] code,
  input  logic              shdn_n,
  output logic [TAPS-1:0]   tap_sel
);
  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_tap
      if (g == 0) begin : g_bend
        assign tap_sel[g] = !shdn_n || (code == CODE_W'(g));
      end else begin : g_mid
        assign tap_sel[g] = shdn_n && (code == CODE_W'(g));
      end
    end
  endgenerate
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
  parameter int unsigned CODE_W      = dpot_pkg::CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TAPS = dpot_pkg::tap_count(CODE_W)
) (
  input  logic              clk,
  input  logic              mid_rst_n,
  input  logic              shdn_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo_pull_low,
  output logic [CODE_W-1:0] wiper_code,
  output logic [TAPS-1:0]   tap_sel,
  output logic              sw_a_closed,
  output logic              wiper_to_b
);
  logic              cs_sync_n, sdi_s, shift_evt, load_evt;
  logic [CODE_W-1:0] sr_q;

  dpot_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rst_n(mid_rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_sync_n(cs_sync_n), .sdi_s(sdi_s), .shift_evt(shift_evt), .load_evt(load_evt)
  );

  dpot_shifter #(.CODE_W(CODE_W)) shifter_i (
    .clk(clk), .rst_n(mid_rst_n), .shift_evt(shift_evt), .load_evt(load_evt),
    .sdi_s(sdi_s), .sr_q(sr_q), .latch_q(wiper_code)
  );

  dpot_decoder #(.CODE_W(CODE_W)) decoder_i (
    .code(wiper_code), .shdn_n(shdn_n), .tap_sel(tap_sel)
  );

  assign sdo_pull_low = !cs_sync_n && shdn_n && !sr_q[CODE_W-1];
  assign sw_a_closed  = shdn_n;
  assign wiper_to_b   = !shdn_n;
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
  parameter int unsigned CODE_W = dpot_pkg::CODE_W_DEF,
  localparam int unsigned TAPS = dpot_pkg::tap_count(CODE_W)
) (
  input logic              clk,
  input logic              mid_rst_n,
  input logic              shdn_n,
  input logic              sdo_pull_low,
  input logic [CODE_W-1:0] wiper_code,
  input logic [TAPS-1:0]   tap_sel,
  input logic              sw_a_closed,
  input logic              wiper_to_b,
  input logic              cs_sync_n,
  input logic              sdi_s,
  input logic              shift_evt,
  input logic              load_evt,
  input logic [CODE_W-1:0] sr_q
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(dpot_pkg::midscale(CODE_W));
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (!mid_rst_n) armed <= 1'b1;
  end

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    shift_evt |=> (sr_q[0] == $past(sdi_s)) && (sr_q[CODE_W-1:1] == $past(sr_q[CODE_W-2:0])));

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    load_evt |=> wiper_code == $past(sr_q));

  a_r4_sdo_enable: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    sdo_pull_low |-> (!cs_sync_n && shdn_n));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    cs_sync_n |=> $stable(sr_q));

  always @(posedge clk) begin
    if (armed && !mid_rst_n) begin
      a_r6_midscale: assert (wiper_code == MID && sr_q == '0);
    end
  end

  a_r7_shdn_flags: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    !shdn_n |-> (!sw_a_closed && wiper_to_b && !sdo_pull_low && tap_sel[0]));

  a_r7_shdn_keeps: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    (!shdn_n && !load_evt) |=> $stable(wiper_code));

  a_r9_onehot: assert property (@(posedge clk) disable iff (!mid_rst_n || !armed)
    $countones(tap_sel) == 1);
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .mid_rst_n(mid_rst_n), .shdn_n(shdn_n), .sdo_pull_low(sdo_pull_low),
  .wiper_code(wiper_code), .tap_sel(tap_sel), .sw_a_closed(sw_a_closed),
  .wiper_to_b(wiper_to_b), .cs_sync_n(cs_sync_n), .sdi_s(sdi_s),
  .shift_evt(shift_evt), .load_evt(load_evt), .sr_q(sr_q)
);

// File: tb/dpot_ctrl_tb_top.sv
module dpot_ctrl_tb_top;
  logic clk = 1'b0;
  logic mid_rst_n = 1'b1, shdn_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic pl_a, pl_b, swa_a, swa_b, wb_a, wb_b;
  logic [6:0] code_a, code_b;
  logic [127:0] tap_a, tap_b;
  logic chain_line;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign chain_line = pl_a ? 1'b0 : 1'b1;

  dpot_ctrl dut_i (
    .clk(clk), .mid_rst_n(mid_rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo_pull_low(pl_a), .wiper_code(code_a), .tap_sel(tap_a),
    .sw_a_closed(swa_a), .wiper_to_b(wb_a)
  );

  dpot_ctrl dut_b_i (
    .clk(clk), .mid_rst_n(mid_rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(chain_line), .sdo_pull_low(pl_b), .wiper_code(code_b), .tap_sel(tap_b),
    .sw_a_closed(swa_b), .wiper_to_b(wb_b)
  );

  function automatic logic [127:0] exp_tap(input logic [6:0] code, input logic off_n);
    logic [127:0] v = '0;
    if (!off_n) v[0] = 1'b1;
    else v[code] = 1'b1;
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] val, input int nbits);
    cs_n = 1'b0;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = val[i];
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n;
    logic off;
    void'($urandom(32'd1234));
    tick(2);
    mid_rst_n = 1'b0;
    tick(3);
    // R6: midscale during reset and after release
    chk("R6 latch in reset", 128'(code_a), 128'h40);
    mid_rst_n = 1'b1;
    tick(4);
    chk("R6 latch after release", 128'(code_a), 128'h40);
    chk("R9 tap at midscale", tap_a, exp_tap(7'h40, 1'b1));
    chk("R9 switch flags", {126'd0, swa_a, wb_a}, 128'b10);
    // R6: reset clears shift register, so a clockless frame loads 0
    frame(32'h0, 0);
    chk("R6 shift reg cleared", 128'(code_a), 128'h00);
    // R1/R2: MSB-first directed load
    frame(32'h5A, 7);
    chk("R1 R2 directed load", 128'(code_a), 128'h5A);
    chk("R4 sdo released with cs high", 128'(chain_line), 128'h1);
    // R5: clocks with cs high do nothing; clockless frame reloads old word
    for (int k = 0; k < 5; k++) begin
      sdi = k[0];
      tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
    end
    chk("R5 latch unchanged", 128'(code_a), 128'h5A);
    frame(32'h0, 0);
    chk("R5 shift reg unchanged", 128'(code_a), 128'h5A);
    // R3: extra leading bits dropped
    frame(32'h3FF, 10);
    chk("R3 ten-bit frame", 128'(code_a), 128'h7F);
    frame(32'h100, 9);
    chk("R3 nine-bit frame", 128'(code_a), 128'h00);
    // R9: end codes
    chk("R9 tap code 0", tap_a, exp_tap(7'h00, 1'b1));
    frame(32'h7F, 7);
    chk("R9 tap code 127", tap_a, exp_tap(7'h7F, 1'b1));
    // R6: cs rise while reset is low loads nothing
    cs_n = 1'b0;
    tick(4);
    sdi = 1'b1; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0; tick(2);
    mid_rst_n = 1'b0;
    cs_n = 1'b1;
    tick(4);
    mid_rst_n = 1'b1;
    tick(6);
    chk("R6 reset beats load", 128'(code_a), 128'h40);
    // Random frames with random shutdown: R3 R7 R8 R9
    for (int it = 0; it < 30; it++) begin
      v = $urandom;
      n = 7 + int'($urandom % 4);
      off = ($urandom % 3) == 0;
      if (off) begin
        shdn_n = 1'b0;
        tick(2);
        chk("R7 shutdown flags", {125'd0, swa_a, wb_a, pl_a}, 128'b010);
        chk("R7 parked tap", tap_a, exp_tap(7'h00, 1'b0));
      end
      frame(v, n);
      chk("R3 R8 random load", 128'(code_a), 128'(v[6:0]));
      chk("R7 R9 tap during frame end", tap_a, exp_tap(v[6:0], !off));
      if (off) begin
        shdn_n = 1'b1;
        tick(2);
        chk("R8 code after release", tap_a, exp_tap(v[6:0], 1'b1));
      end
    end
    // R7: latch held through shutdown without a load
    frame(32'h21, 7);
    shdn_n = 1'b0;
    tick(10);
    chk("R7 latch held", 128'(code_a), 128'h21);
    shdn_n = 1'b1;
    tick(2);
    chk("R7 restore", tap_a, exp_tap(7'h21, 1'b1));
    // R4: daisy chain of fourteen-bit frames
    for (int it = 0; it < 12; it++) begin
      v = $urandom;
      frame(v, 14);
      chk("R4 chain near device", 128'(code_a), 128'(v[6:0]));
      chk("R4 chain far device", 128'(code_b), 128'(v[13:7]));
    end
    summary();
  end
endmodule